// File: doc/BRIEF.md
# Pixel Bit-Plane Transpose Unit

This block takes a stream of 8-bit gray levels for one colour channel and turns it into bit-plane words. Pixels arrive one byte per handshake and are stored as the rows of a small bit matrix. Once a group of eight pixels is complete, the matrix is read out by column. Each column word holds the bits of one binary weight, taken from all eight pixels. Weighted-scan display drivers consume data in this form, since each scan pass lights the LEDs for a single bit weight.

Two matrices alternate. While one is being read out, the other fills, so a source and a sink that are both always ready move one byte in and one plane out every cycle. Each matrix has its own two-state machine: `BK_OPEN` means it accepts pixels and `BK_LOADED` means it holds a complete group. The transition `BK_OPEN -> BK_LOADED` fires when the eighth byte of a group is accepted. The transition `BK_LOADED -> BK_OPEN` fires when the last plane of that group is taken. A write pointer and a read pointer toggle between the two matrices on those same events.

Top module: `bitplane_xpose`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Bit i of the plane word with index k equals bit k of the i-th pixel of its group, with pixel 0 in bit 0.
- R3: The planes of a group leave in order, with `out_plane` = 0, 1, ... 7, and every accepted plane is produced exactly once.
- R4: A group produces no output until all eight of its bytes are accepted. A partial group stays held across input gaps of any length and needs no padding.
- R5: When the sink is always ready, `in_ready` stays 1 during continuous streaming, including the cycle where one group completes while the other group's last plane leaves.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_bits` and `out_plane` stay unchanged and `out_valid` stays 1.
- R7: When both matrices hold complete groups, `in_ready` is 0 and bytes that are offered have no effect on later output.
- R8: Reset discards a partial group. The next eight bytes form a fresh group that starts at pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel byte offered |
| in_ready | output | 1 | Pixel byte can be accepted |
| in_pixel | input | PIX_W | Gray level of one pixel |
| out_valid | output | 1 | Plane word available |
| out_ready | input | 1 | Sink takes the plane word |
| out_bits | output | GRP | Bits of one weight, pixel 0 in bit 0 |
| out_plane | output | clog2(PIX_W) | Weight index of `out_bits` |

## Verification
Two events can fall in the same clock edge: the eighth byte filling one matrix and the eighth plane leaving the other matrix. On that edge both state machines change state and both pointers toggle. The bench provokes this by streaming several groups back to back with the sink held ready. It judges the result by checking that `in_ready` never drops and that every plane word, with its tag, matches the transpose computed from the requirements. A separate backpressure run fills both matrices and then confirms that input is refused and that the held plane stays stable.

// File: rtl/xp_pkg.sv
package xp_pkg;
    typedef enum logic {
        BK_OPEN   = 1'b0,
        BK_LOADED = 1'b1
    } bank_st_t;
endpackage

// File: rtl/xp_bank.sv
module xp_bank #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_row,
    input  logic [COLS-1:0] wr_data,
    input  logic [CW-1:0]   rd_col,
    output logic [ROWS-1:0] rd_word
);
    logic [COLS-1:0] mat_q [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                mat_q[r] <= '0;
            end
        end else if (wr_en) begin
            mat_q[wr_row] <= wr_data;
        end
    end

    // column read: one bit from every row
    for (genvar r = 0; r < ROWS; r++) begin : g_col
        assign rd_word[r] = mat_q[r][rd_col];
    end
endmodule

// File: rtl/xp_ctrl.sv
module xp_ctrl
    import xp_pkg::*;
#(
    parameter int GRP   = 8,
    parameter int PIX_W = 8,
    localparam int RW = $clog2(GRP),
    localparam int CW = $clog2(PIX_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic [1:0]    wr_en,
    output logic [RW-1:0] wr_row,
    output logic          rd_sel,
    output logic [CW-1:0] rd_col
);
    bank_st_t      st_q [2];
    bank_st_t      st_d [2];
    logic          wr_sel_q, rd_sel_q;
    logic [RW-1:0] fill_q;
    logic [CW-1:0] drain_q;
    logic          in_fire, out_fire, fill_last, drain_last;

    assign fill_last  = (fill_q == RW'(GRP - 1));
    assign drain_last = (drain_q == CW'(PIX_W - 1));
    assign in_fire    = in_valid && in_ready;
    assign out_fire   = out_valid && out_ready;

    // state register for both banks
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q[0] <= BK_OPEN;
            st_q[1] <= BK_OPEN;
        end else begin
            st_q[0] <= st_d[0];
            st_q[1] <= st_d[1];
        end
    end

    // per-bank next state
    for (genvar b = 0; b < 2; b++) begin : g_fsm
        always_comb begin
            st_d[b] = st_q[b];
            unique case (st_q[b])
                BK_OPEN: begin
                    if (in_fire && wr_sel_q == 1'(b) && fill_last) begin
                        st_d[b] = BK_LOADED;
                    end
                end
                BK_LOADED: begin
                    if (out_fire && rd_sel_q == 1'(b) && drain_last) begin
                        st_d[b] = BK_OPEN;
                    end
                end
                default: st_d[b] = BK_OPEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = (st_q[wr_sel_q] == BK_OPEN);
        out_valid = (st_q[rd_sel_q] == BK_LOADED);
        wr_en     = '0;
        wr_en[wr_sel_q] = in_fire;
        wr_row    = fill_q;
        rd_sel    = rd_sel_q;
        rd_col    = drain_q;
    end

    // fill and drain counters with bank pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q   <= '0;
            drain_q  <= '0;
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
        end else begin
            if (in_fire) begin
                if (fill_last) begin
                    fill_q   <= '0;
                    wr_sel_q <= ~wr_sel_q;
                end else begin
                    fill_q <= fill_q + 1'b1;
                end
            end
            if (out_fire) begin
                if (drain_last) begin
                    drain_q  <= '0;
                    rd_sel_q <= ~rd_sel_q;
                end else begin
                    drain_q <= drain_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bitplane_xpose.sv
module bitplane_xpose #(
    parameter int PIX_W = 8,
    parameter int GRP   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PIX_W-1:0]         in_pixel,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [GRP-1:0]           out_bits,
    output logic [$clog2(PIX_W)-1:0] out_plane
);
    localparam int RW = $clog2(GRP);
    localparam int CW = $clog2(PIX_W);

    logic [1:0]    wr_en;
    logic [RW-1:0] wr_row;
    logic          rd_sel;
    logic [CW-1:0] rd_col;
    logic [GRP-1:0] bank_word [2];

    xp_ctrl #(.GRP(GRP), .PIX_W(PIX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .rd_sel    (rd_sel),
        .rd_col    (rd_col)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        xp_bank #(.ROWS(GRP), .COLS(PIX_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[b]),
            .wr_row  (wr_row),
            .wr_data (in_pixel),
            .rd_col  (rd_col),
            .rd_word (bank_word[b])
        );
    end

    assign out_bits  = bank_word[rd_sel];
    assign out_plane = rd_col;
endmodule

// File: rtl/xp_chk.sv
module xp_chk #(
    parameter int PIX_W = 8,
    parameter int GRP   = 8,
    localparam int CW = $clog2(PIX_W),
    localparam int RW = $clog2(GRP)
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [GRP-1:0] out_bits,
    input logic [CW-1:0]  out_plane
);
    logic [RW-1:0] seen_q;
    logic [1:0]    pend_q;
    logic          grp_in, grp_out;

    assign grp_in  = in_valid && in_ready && (seen_q == RW'(GRP - 1));
    assign grp_out = out_valid && out_ready && (out_plane == CW'(PIX_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            pend_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                seen_q <= (seen_q == RW'(GRP - 1)) ? '0 : seen_q + 1'b1;
            end
            pend_q <= pend_q + {1'b0, grp_in} - {1'b0, grp_out};
        end
    end

    // R6
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_plane));

    // R3
    plane_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_plane != CW'(PIX_W - 1)
        |=> out_valid && out_plane == CW'($past(out_plane) + 1'b1));

    // R3
    plane_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_plane == CW'(PIX_W - 1) |=> out_plane == '0);

    // R4
    no_early_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> pend_q != 2'd0);

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q == 2'd2 |-> !in_ready);

    // R5
    open_accept_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q < 2'd2 |-> in_ready);
endmodule

bind bitplane_xpose xp_chk #(.PIX_W(PIX_W), .GRP(GRP)) u_xp_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bits  (out_bits),
    .out_plane (out_plane)
);

// File: tb/test_bitplane_xpose.sv
module test_bitplane_xpose;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pixel = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_bits;
    logic [2:0] out_plane;

    int checks = 0;
    int fails  = 0;
    int stalls = 0;
    logic [7:0] exp_bits [$];
    logic [2:0] exp_plane [$];

    // pixel 0 in the low byte
    localparam logic [63:0] GROUPS [4] = '{
        64'h0706050403020100,
        64'h8040201008040201,
        64'hFF00FF00FF00FF00,
        64'h0123456789ABCDEF
    };

    always #5 clk = ~clk;

    bitplane_xpose i_bitplane_xpose (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
        .out_bits(out_bits), .out_plane(out_plane)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] plane_of(input logic [63:0] g, input int k);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = g[8*i+k];
        return r;
    endfunction

    task automatic expect_group(input logic [63:0] g);
        for (int k = 0; k < 8; k++) begin
            exp_bits.push_back(plane_of(g, k));
            exp_plane.push_back(3'(k));
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_pixel = b;
        #3;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #3;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // output monitor, samples 2 ns before the rising edge
    always @(negedge clk) begin
        #3;
        if (!rst && out_valid && out_ready) begin
            if (exp_bits.size() == 0) begin
                chk(1'b0, "R3 unexpected plane", {out_plane, out_bits}, 0);
            end else begin
                logic [7:0] eb;
                logic [2:0] ep;
                eb = exp_bits.pop_front();
                ep = exp_plane.pop_front();
                chk(out_bits == eb && out_plane == ep, "R2 R3 plane word",
                    {out_plane, out_bits}, {ep, eb});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] h0, h1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        chk(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 2'b01);

        // table walk: continuous streaming with ready sink
        stalls = 0;
        foreach (GROUPS[g]) begin
            expect_group(GROUPS[g]);
            for (int i = 0; i < 8; i++) push(GROUPS[g][8*i +: 8]);
        end
        chk(stalls == 0, "R5 no input stall", stalls, 0);
        idle(12);
        chk(exp_bits.size() == 0, "R3 all planes out", exp_bits.size(), 0);

        // partial group held across a gap
        expect_group(64'h3C5A96F00F69A5C3);
        for (int i = 0; i < 7; i++) push(8'(64'h3C5A96F00F69A5C3 >> (8*i)));
        idle(10);
        #3;
        chk(!out_valid, "R4 partial group silent", out_valid, 0);
        push(8'h3C);
        idle(12);
        chk(exp_bits.size() == 0, "R4 group completes", exp_bits.size(), 0);

        // backpressure: fill both banks
        out_ready = 1'b0;
        expect_group(64'hAA55AA55AA55AA55);
        expect_group(64'h0F0F0F0FF0F0F0F0);
        for (int i = 0; i < 8; i++) push(8'(64'hAA55AA55AA55AA55 >> (8*i)));
        for (int i = 0; i < 8; i++) push(8'(64'h0F0F0F0FF0F0F0F0 >> (8*i)));
        @(negedge clk);
        in_valid = 1'b1;
        in_pixel = 8'hEE;
        #3;
        chk(!in_ready, "R7 both banks full", in_ready, 0);
        h0 = out_bits;
        chk(out_valid && out_plane == 3'd0, "R6 held plane tag", {out_valid, out_plane}, 4'b1000);
        repeat (4) @(negedge clk);
        #3;
        h1 = out_bits;
        chk(h0 == h1 && out_plane == 3'd0, "R6 held word stable", {out_plane, h1}, {3'd0, h0});
        chk(!in_ready, "R7 still refusing", in_ready, 0);
        in_valid = 1'b0;
        out_ready = 1'b1;
        idle(20);
        chk(exp_bits.size() == 0, "R7 drained", exp_bits.size(), 0);
        // refused byte must not have entered: fresh group starts at pixel 0
        expect_group(64'h1122334455667788);
        for (int i = 0; i < 8; i++) push(8'(64'h1122334455667788 >> (8*i)));
        idle(12);
        chk(exp_bits.size() == 0, "R7 refused byte ignored", exp_bits.size(), 0);

        // reset in the middle of a group
        for (int i = 0; i < 3; i++) push(8'hFF);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #3;
        chk(!out_valid && in_ready, "R8 reset clears", {out_valid, in_ready}, 2'b01);
        expect_group(64'h8000000000000001);
        for (int i = 0; i < 8; i++) push(8'(64'h8000000000000001 >> (8*i)));
        idle(12);
        chk(exp_bits.size() == 0, "R8 fresh group", exp_bits.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule